// File: doc/BRIEF.md
# Byte-Wide Register Bridge for a 32-bit AHB-Lite Bus

This block is an AHB-Lite slave that places a small byte-wide register array on a 32-bit little-endian data bus. It registers the address-phase controls while HREADY is high. In the following data phase it stores one byte of HWDATA for a write, or returns one stored byte for a read.

For a write, the two low bits of the registered address select the active byte lane. Offset 0 takes HWDATA[7:0], offset 1 takes HWDATA[15:8], offset 2 takes HWDATA[23:16] and offset 3 takes HWDATA[31:24]. For a read, the block copies the addressed byte onto all four HRDATA lanes, and the master keeps the lane that matches its own address.

Only byte-sized accesses are accepted. A halfword or word access gets the two-cycle ERROR response. Byte accesses, idle cycles and unselected cycles complete with no wait states.

Top module: `byte_lane_bridge`

## Requirements
- R1: After HRESETn is released, every stored byte reads as zero, HREADYOUT is 1, HRESP is 0 (OKAY) and HRDATA is zero.
- R2: A byte write (HSIZE=000) to byte address A stores HWDATA[8*(A mod 4)+7 : 8*(A mod 4)] into byte A. All other bytes, including the other bytes of the same word, keep their values.
- R3: During the data phase of a byte read from address A, all four 8-bit lanes of HRDATA carry byte A.
- R4: Address-phase signals are taken on a rising edge where HREADY is 1. The write data is the HWDATA present in the following cycle; HWDATA during the address phase has no effect.
- R5: A transfer is acted on only when HSEL is 1 and HTRANS is NONSEQ (10) or SEQ (11). IDLE (00), BUSY (01) or HSEL=0 stores nothing and gets a zero-wait OKAY data phase.
- R6: A byte access completes in its first data-phase cycle: HREADYOUT is 1 and HRESP is 0.
- R7: A selected active access with HSIZE 001 or 010 gets the two-cycle ERROR response and stores nothing. In the first cycle HREADYOUT is 0 and HRESP is 1; in the second, HREADYOUT is 1 and HRESP is 1.
- R8: HRDATA is zero in every cycle that is not the data phase of a byte read.
- R9: A byte read whose address phase overlaps the data phase of a write to the same byte returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | ABITS | Low byte-address bits of the transfer |
| htrans | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| hwrite | input | 1 | 1 for a write, 0 for a read |
| hsize | input | 3 | Transfer size: 000 byte, 001 halfword, 010 word |
| hready | input | 1 | Bus-wide ready; the previous transfer is complete |
| hwdata | input | 32 | Write data bus |
| hrdata | output | 32 | Read data bus, with the byte replicated on all lanes |
| hreadyout | output | 1 | Ready output of this slave |
| hresp | output | 1 | 0 for OKAY, 1 for ERROR |

## Verification
The bench builds the block with ABITS=4, which gives a 16-byte array. Every byte address and every lane offset can therefore be written and read back in full, more than once with different patterns. Each write word fills all four lanes with distinct values, so taking the wrong lane gives a wrong byte. A full readback after each phase shows any clobbered neighbour, any write made by an ignored transfer, and any write made by a rejected wide access. Back-to-back write-then-read pairs on every address test the pipeline overlap.

// File: rtl/byte_lane_bridge.sv
`timescale 1ns/1ps
module byte_lane_bridge #(
  parameter int ABITS = 4
) (
  input  logic             hclk,
  input  logic             hresetn,
  input  logic             hsel,
  input  logic [ABITS-1:0] haddr,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic             hready,
  input  logic [31:0]      hwdata,
  output logic [31:0]      hrdata,
  output logic             hreadyout,
  output logic             hresp
);
  localparam int DEPTH = 1 << ABITS;

  logic [7:0]       mem [DEPTH];
  logic             dp_wr, dp_rd, err1, err2;
  logic [ABITS-1:0] dp_addr;
  logic             req, is_byte;
  logic [7:0]       rd_byte, wr_byte;

  assign req     = hsel && htrans[1];
  assign is_byte = (hsize == 3'b000);
  assign wr_byte = hwdata[8*dp_addr[1:0] +: 8];
  assign rd_byte = mem[dp_addr];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      dp_wr   <= 1'b0;
      dp_rd   <= 1'b0;
      err1    <= 1'b0;
      err2    <= 1'b0;
      dp_addr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      err2 <= err1;
      if (hready) begin
        dp_wr   <= req && is_byte && hwrite;
        dp_rd   <= req && is_byte && !hwrite;
        err1    <= req && !is_byte;
        dp_addr <= haddr;
      end else begin
        dp_wr <= 1'b0;
        dp_rd <= 1'b0;
        err1  <= 1'b0;
      end
      if (dp_wr) mem[dp_addr] <= wr_byte;
    end
  end

  assign hrdata    = dp_rd ? {4{rd_byte}} : 32'h0;
  assign hreadyout = !err1;
  assign hresp     = err1 || err2;

  AST_LANES_MATCH: assert property (@(posedge hclk) disable iff (!hresetn)
    (hrdata[15:8] == hrdata[7:0]) && (hrdata[23:16] == hrdata[7:0]) && (hrdata[31:24] == hrdata[7:0])); // R3
  AST_BYTE_OKAY: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && hsel && htrans[1] && hsize == 3'b000) |=> (hreadyout && !hresp)); // R6
  AST_IDLE_OKAY: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !(hsel && htrans[1])) |=> (hreadyout && !hresp && hrdata == 32'h0)); // R5
  AST_WIDE_ERR_FIRST: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && hsel && htrans[1] && hsize != 3'b000) |=> (!hreadyout && hresp)); // R7
  AST_WIDE_ERR_SECOND: assert property (@(posedge hclk) disable iff (!hresetn)
    $fell(hreadyout) |=> (hreadyout && hresp)); // R7
  AST_WAIT_ONLY_ON_ERR: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |-> hresp); // R7
  AST_WRITE_NO_RDATA: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && hsel && htrans[1] && hwrite) |=> (hrdata == 32'h0)); // R8
endmodule

// File: tb/byte_lane_bridge_tb.sv
`timescale 1ns/1ps
module byte_lane_bridge_tb;
  localparam int ABITS = 4;
  localparam int DEPTH = 1 << ABITS;

  logic             hclk = 1'b0;
  logic             hresetn = 1'b0;
  logic             hsel = 1'b0;
  logic [ABITS-1:0] haddr = '0;
  logic [1:0]       htrans = 2'b00;
  logic             hwrite = 1'b0;
  logic [2:0]       hsize = 3'b000;
  logic             hready;
  logic [31:0]      hwdata = '0;
  logic [31:0]      hrdata;
  logic             hreadyout, hresp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #10 hclk = ~hclk;
  assign hready = hreadyout;

  byte_lane_bridge #(.ABITS(ABITS)) u_dut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready), .hwdata(hwdata),
    .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int lane, input int seed);
    return 8'((a * 37 + lane * 11 + seed * 71) ^ 8'h5A);
  endfunction

  function automatic logic [31:0] word_of(input int a, input int seed);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) w[8*l +: 8] = pat(a, l, seed);
    return w;
  endfunction

  task automatic idle_phase();
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hsize = 3'b000;
  endtask

  task automatic tick();
    @(posedge hclk); #1;
  endtask

  task automatic do_write(input int a, input int seed);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'b000; haddr = ABITS'(a);
    hwdata = ~word_of(a, seed);
    tick();
    idle_phase();
    hwdata = word_of(a, seed);
    chk(hreadyout && !hresp, "R6 write okay", {30'h0, hreadyout, hresp}, 32'h2);
    chk(hrdata == 32'h0, "R8 rdata zero in write", hrdata, 32'h0);
    model[a] = pat(a, a % 4, seed);
    tick();
  endtask

  task automatic do_read(input int a, input string req);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; hsize = 3'b000; haddr = ABITS'(a);
    tick();
    idle_phase();
    chk(hrdata == {4{model[a]}}, req, hrdata, {4{model[a]}});
    chk(hreadyout && !hresp, "R6 read okay", {30'h0, hreadyout, hresp}, 32'h2);
    tick();
    chk(hrdata == 32'h0, "R8 rdata zero after read", hrdata, 32'h0);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < DEPTH; a++) do_read(a, req);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    repeat (3) @(posedge hclk);
    #1 hresetn = 1'b1;
    chk(hreadyout && !hresp, "R1 reset handshake", {30'h0, hreadyout, hresp}, 32'h2);
    chk(hrdata == 32'h0, "R1 reset rdata", hrdata, 32'h0);
    tick();
    read_all("R1 reset contents zero");

    for (int a = 0; a < DEPTH; a++) do_write(a, 1);
    read_all("R2 R3 lane write then replicated read");
    for (int a = 1; a < DEPTH; a += 2) do_write(a, 2);
    read_all("R2 neighbours kept");

    for (int k = 0; k < 3; k++) begin
      for (int a = 0; a < DEPTH; a++) begin
        hsel = (k != 2); htrans = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b10;
        hwrite = 1'b1; hsize = 3'b000; haddr = ABITS'(a);
        tick();
        idle_phase();
        hwdata = 32'hFFFF_FFFF;
        chk(hreadyout && !hresp, "R5 ignored transfer okay", {30'h0, hreadyout, hresp}, 32'h2);
        tick();
      end
    end
    read_all("R5 ignored transfers store nothing");

    for (int sz = 1; sz <= 2; sz++) begin
      for (int a = 0; a < DEPTH; a += 4) begin
        for (int w = 0; w < 2; w++) begin
          hsel = 1'b1; htrans = 2'b10; hwrite = (w == 1); hsize = 3'(sz); haddr = ABITS'(a);
          tick();
          idle_phase();
          hwdata = 32'hA5C3_3C5A;
          chk(!hreadyout && hresp, "R7 error first cycle", {30'h0, hreadyout, hresp}, 32'h1);
          tick();
          chk(hreadyout && hresp, "R7 error second cycle", {30'h0, hreadyout, hresp}, 32'h3);
          tick();
          chk(hreadyout && !hresp, "R7 error ends", {30'h0, hreadyout, hresp}, 32'h2);
        end
      end
    end
    read_all("R7 wide access stores nothing");

    for (int a = 0; a < DEPTH; a++) begin
      hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'b000; haddr = ABITS'(a);
      hwdata = 32'h0;
      tick();
      hwdata = word_of(a, 3);
      model[a] = pat(a, a % 4, 3);
      htrans = 2'b11; hwrite = 1'b0;
      tick();
      idle_phase();
      chk(hrdata == {4{model[a]}}, "R9 R4 back-to-back read", hrdata, {4{model[a]}});
      tick();
    end
    read_all("R4 data-phase data stored");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule